// File: doc/BRIEF.md
# Floating-Point Add/Subtract Unit with Selectable Rounding

This block adds or subtracts two numbers held in a compact floating-point format. Each operand has an unsigned excess-coded exponent of `EXP_W` bits and a two's-complement mantissa of `MAN_W` bits. The mantissa carries no hidden bit and is normalized, which means its two most significant bits differ. A value is read as `mantissa / 2^(MAN_W-1) * 2^(exponent - bias)`. The bias of 2^(EXP_W-1) cancels out of every operation, so the block only ever compares and adjusts the biased exponent fields.

An operation starts with a one-cycle `start` pulse while the unit is idle. The unit then takes the larger exponent as the working exponent and shifts the mantissa of the other operand right to line it up. It adds or subtracts the two mantissas and normalizes the result. Finally it rounds the result to `MAN_W` bits using one of three policies. Inside the unit, each mantissa carries three extra low bits: a first guard bit, a second guard bit and a sticky bit. The result is available exactly four clock edges after the start edge. It stays on the outputs until the next result replaces it.

Top module: `fpx_addsub`

## Requirements
- R1: Alignment keeps the larger of the two exponent fields as the working exponent. It arithmetically shifts the mantissa of the other operand right by the exponent difference. For example, exponent 0x84 with mantissa 0x44 plus exponent 0x83 with mantissa 0x70 gives exponent 0x84 and mantissa 0x7C.
- R2: With `sub` high the result is A minus B. With `sub` low it is A plus B.
- R3: Each mantissa is extended below its LSB by three zero bits, forming `MAN_W+3` bits (guard 1, guard 2, sticky). During alignment, any 1 shifted out below the lowest extended bit is ORed into that lowest bit. When the difference reaches `MAN_W+3` or more, only sign bits and the sticky bit remain.
- R4: If the raw sum no longer fits in `MAN_W+3` signed bits, it is shifted right once and the exponent goes up by one. The bit dropped by that shift is ORed into the new lowest bit.
- R5: Otherwise the sum is shifted left until its two top bits differ. The exponent goes down by one for each shift, and the tail bits move up into the mantissa.
- R6: An exactly zero sum gives a zero exponent field, a zero mantissa and both flags low, whatever the operand exponents were.
- R7: `rmode` = 0 (truncate): the three tail bits are dropped.
- R8: `rmode` = 1 (jam): the tail bits are dropped and mantissa bit 0 is forced to 1.
- R9: `rmode` = 2 or 3 (nearest): with the tail read as an unsigned 3-bit value, tails 0 to 3 truncate and tails 5 to 7 add one at the LSB. Tail 4 adds one only when the kept LSB is 1.
- R10: If rounding turns the largest positive mantissa into an out-of-range value, the result becomes 0x40 (for `MAN_W`=8) and the exponent goes up by one. If rounding turns a negative mantissa into -2^(MAN_W-2), the result becomes the most negative mantissa and the exponent goes down by one.
- R11: `exp_ovf` is set when the final exponent exceeds 2^EXP_W-1. `exp_unf` is set when it falls below zero. In both cases `r_exp` carries the low `EXP_W` bits of the true exponent.
- R12: `start` is accepted only while `busy` is low. `busy` then stays high for four cycles. `done` pulses for one cycle, starting four edges after the accepting edge, and the result ports change only in that cycle. A `start` while busy is ignored.
- R13: After reset, `busy`, `done`, `r_exp`, `r_man`, `exp_ovf` and `exp_unf` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled while idle |
| sub | input | 1 | 1 selects A minus B, 0 selects A plus B |
| rmode | input | 2 | Rounding policy: 0 truncate, 1 jam LSB, 2 and 3 nearest |
| a_exp | input | EXP_W | Excess-coded exponent of A |
| a_man | input | MAN_W | Two's-complement mantissa of A |
| b_exp | input | EXP_W | Excess-coded exponent of B |
| b_man | input | MAN_W | Two's-complement mantissa of B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result ports just updated |
| r_exp | output | EXP_W | Result exponent |
| r_man | output | MAN_W | Result mantissa |
| exp_ovf | output | 1 | Result exponent above range |
| exp_unf | output | 1 | Result exponent below zero |

## Verification
The bench builds the unit with its default 8-bit exponent and 8-bit mantissa. With these widths, an exponent difference of 16 is enough to push an entire operand into the sticky bit. The field extremes 0x02 and 0xFF are also easy to reach, which lets both range flags fire. The small mantissa makes each rounding tail, and both renormalization cases after rounding, reachable with hand-picked operands. These directed cases run alongside a long stretch of random back-to-back and overlapping starts, and a behavioural integer model checks every cycle of that stretch.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;

   // Number of low bits appended to each mantissa: guard 1, guard 2, sticky
   localparam int TAIL_W = 3;

   typedef enum logic [1:0] {
      RND_CHOP     = 2'd0,
      RND_JAM      = 2'd1,
      RND_NEAR     = 2'd2,
      RND_NEAR_ALT = 2'd3
   } rnd_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ALIGN = 3'd1,
      ST_SUM   = 3'd2,
      ST_NORM  = 3'd3,
      ST_ROUND = 3'd4
   } fsm_state_e;

endpackage

// File: rtl/fpx_align.sv
`timescale 1ns/1ps
module fpx_align #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 8
) (
   input  logic [EXP_W-1:0]                 a_exp,
   input  logic [EXP_W-1:0]                 b_exp,
   input  logic [MAN_W-1:0]                 a_man,
   input  logic [MAN_W-1:0]                 b_man,
   output logic [EXP_W-1:0]                 big_exp,
   output logic [MAN_W+fpx_pkg::TAIL_W-1:0] a_ext,
   output logic [MAN_W+fpx_pkg::TAIL_W-1:0] b_ext
);
   localparam int XW = MAN_W + fpx_pkg::TAIL_W;
   localparam int AW = $clog2(XW + 1);

   logic             b_larger;
   logic [EXP_W-1:0] diff;
   logic [AW-1:0]    amt;
   logic [XW-1:0]    small_full;
   logic [XW-1:0]    shifted;
   logic [XW-1:0]    lost_bits;
   logic             lost;
   logic [XW-1:0]    small_ext;

   assign b_larger   = b_exp > a_exp;
   assign diff       = b_larger ? (b_exp - a_exp) : (a_exp - b_exp);
   // distances at or beyond the extended width leave only sign and sticky
   assign amt        = (diff >= EXP_W'(XW)) ? AW'(XW) : AW'(diff);
   assign small_full = b_larger ? {a_man, {fpx_pkg::TAIL_W{1'b0}}}
                                : {b_man, {fpx_pkg::TAIL_W{1'b0}}};
   assign shifted    = $signed(small_full) >>> amt;

   // one detector per bit position: set when a 1 leaves the word
   for (genvar i = 0; i < XW; i++) begin : g_lost
      assign lost_bits[i] = small_full[i] & (amt > AW'(i));
   end

   assign lost      = |lost_bits;
   assign small_ext = {shifted[XW-1:1], shifted[0] | lost};

   assign big_exp = b_larger ? b_exp : a_exp;
   assign a_ext   = b_larger ? small_ext : {a_man, {fpx_pkg::TAIL_W{1'b0}}};
   assign b_ext   = b_larger ? {b_man, {fpx_pkg::TAIL_W{1'b0}}} : small_ext;

endmodule

// File: rtl/fpx_normalize.sv
`timescale 1ns/1ps
module fpx_normalize #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 8
) (
   input  logic [MAN_W+fpx_pkg::TAIL_W:0]   sum,
   input  logic [EXP_W-1:0]                 e_in,
   output logic [MAN_W+fpx_pkg::TAIL_W-1:0] norm,
   output logic [EXP_W+1:0]                 e_out,
   output logic                             is_zero
);
   localparam int XW = MAN_W + fpx_pkg::TAIL_W;
   localparam int SW = XW + 1;
   localparam int CW = $clog2(XW);

   logic          carry_out;
   logic [XW-1:0] low;
   logic [CW-1:0] lsc;

   assign carry_out = sum[SW-1] ^ sum[SW-2];
   assign low       = sum[XW-1:0];
   assign is_zero   = (sum == '0);

   // left shift distance: the highest bit that differs from the sign
   always_comb begin
      lsc = CW'(XW - 1);
      for (int j = 0; j < XW - 1; j++) begin
         if (low[j] != low[XW-1]) lsc = CW'(XW - 2 - j);
      end
   end

   always_comb begin
      if (carry_out) begin
         norm  = {sum[SW-1:2], sum[1] | sum[0]};
         e_out = {2'b00, e_in} + (EXP_W+2)'(1);
      end else begin
         norm  = low << lsc;
         e_out = {2'b00, e_in} - (EXP_W+2)'(lsc);
      end
   end

endmodule

// File: rtl/fpx_round.sv
`timescale 1ns/1ps
module fpx_round #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 8
) (
   input  logic [MAN_W+fpx_pkg::TAIL_W-1:0] norm,
   input  logic [EXP_W+1:0]                 e_in,
   input  fpx_pkg::rnd_mode_e               mode,
   output logic [MAN_W-1:0]                 man,
   output logic [EXP_W+1:0]                 e_out
);
   localparam int TW = fpx_pkg::TAIL_W;
   localparam logic [TW-1:0] HALF = {1'b1, {(TW-1){1'b0}}};

   logic [MAN_W-1:0] kept;
   logic [MAN_W-1:0] kept_f;
   logic [TW-1:0]    tail;
   logic             inc;
   logic [MAN_W:0]   r;

   assign kept = norm[MAN_W+TW-1:TW];
   assign tail = norm[TW-1:0];

   always_comb begin
      kept_f = kept;
      inc    = 1'b0;
      case (mode)
         fpx_pkg::RND_CHOP: inc = 1'b0;
         fpx_pkg::RND_JAM:  kept_f = kept | MAN_W'(1);
         default:           inc = (tail > HALF) | ((tail == HALF) & kept[0]);
      endcase
   end

   assign r = {kept_f[MAN_W-1], kept_f} + {{MAN_W{1'b0}}, inc};

   always_comb begin
      if (r[MAN_W] != r[MAN_W-1]) begin
         man   = r[MAN_W:1];
         e_out = e_in + (EXP_W+2)'(1);
      end else if (r[MAN_W-1] == r[MAN_W-2]) begin
         man   = {r[MAN_W-2:0], 1'b0};
         e_out = e_in - (EXP_W+2)'(1);
      end else begin
         man   = r[MAN_W-1:0];
         e_out = e_in;
      end
   end

endmodule

// File: rtl/fpx_addsub.sv
`timescale 1ns/1ps
module fpx_addsub import fpx_pkg::*; #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sub,
   input  logic [1:0]       rmode,
   input  logic [EXP_W-1:0] a_exp,
   input  logic [MAN_W-1:0] a_man,
   input  logic [EXP_W-1:0] b_exp,
   input  logic [MAN_W-1:0] b_man,
   output logic             busy,
   output logic             done,
   output logic [EXP_W-1:0] r_exp,
   output logic [MAN_W-1:0] r_man,
   output logic             exp_ovf,
   output logic             exp_unf
);
   localparam int XW = MAN_W + TAIL_W;
   localparam int SW = XW + 1;

   if (MAN_W < 4) begin : g_bad_man
      $error("fpx_addsub: MAN_W must be at least 4");
   end
   if (EXP_W < 3 || (2 ** EXP_W) <= XW) begin : g_bad_exp
      $error("fpx_addsub: EXP_W too narrow for the shift range");
   end

   fsm_state_e       state;
   logic [EXP_W-1:0] ea_q, eb_q, big_q;
   logic [MAN_W-1:0] ma_q, mb_q;
   logic             sub_q;
   rnd_mode_e        mode_q;
   logic [XW-1:0]    xa_q, xb_q;
   logic [SW-1:0]    sum_q;
   logic [XW-1:0]    norm_q;
   logic [EXP_W+1:0] en_q;
   logic             zero_q;

   logic [EXP_W-1:0] big_d;
   logic [XW-1:0]    xa_d, xb_d;
   logic [SW-1:0]    sum_d;
   logic [XW-1:0]    norm_d;
   logic [EXP_W+1:0] en_d;
   logic             zero_d;
   logic [MAN_W-1:0] man_d;
   logic [EXP_W+1:0] ef_d;

   fpx_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
      .a_exp   (ea_q),
      .b_exp   (eb_q),
      .a_man   (ma_q),
      .b_man   (mb_q),
      .big_exp (big_d),
      .a_ext   (xa_d),
      .b_ext   (xb_d)
   );

   assign sum_d = sub_q ? ({xa_q[XW-1], xa_q} - {xb_q[XW-1], xb_q})
                        : ({xa_q[XW-1], xa_q} + {xb_q[XW-1], xb_q});

   fpx_normalize #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
      .sum     (sum_q),
      .e_in    (big_q),
      .norm    (norm_d),
      .e_out   (en_d),
      .is_zero (zero_d)
   );

   fpx_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
      .norm  (norm_q),
      .e_in  (en_q),
      .mode  (mode_q),
      .man   (man_d),
      .e_out (ef_d)
   );

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ea_q    <= '0;
         eb_q    <= '0;
         ma_q    <= '0;
         mb_q    <= '0;
         sub_q   <= 1'b0;
         mode_q  <= RND_CHOP;
         big_q   <= '0;
         xa_q    <= '0;
         xb_q    <= '0;
         sum_q   <= '0;
         norm_q  <= '0;
         en_q    <= '0;
         zero_q  <= 1'b0;
         done    <= 1'b0;
         r_exp   <= '0;
         r_man   <= '0;
         exp_ovf <= 1'b0;
         exp_unf <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  ea_q   <= a_exp;
                  eb_q   <= b_exp;
                  ma_q   <= a_man;
                  mb_q   <= b_man;
                  sub_q  <= sub;
                  mode_q <= rnd_mode_e'(rmode);
                  state  <= ST_ALIGN;
               end
            end
            ST_ALIGN: begin
               big_q <= big_d;
               xa_q  <= xa_d;
               xb_q  <= xb_d;
               state <= ST_SUM;
            end
            ST_SUM: begin
               sum_q <= sum_d;
               state <= ST_NORM;
            end
            ST_NORM: begin
               norm_q <= norm_d;
               en_q   <= en_d;
               zero_q <= zero_d;
               state  <= ST_ROUND;
            end
            ST_ROUND: begin
               done  <= 1'b1;
               state <= ST_IDLE;
               if (zero_q) begin
                  r_exp   <= '0;
                  r_man   <= '0;
                  exp_ovf <= 1'b0;
                  exp_unf <= 1'b0;
               end else begin
                  r_exp   <= ef_d[EXP_W-1:0];
                  r_man   <= man_d;
                  exp_ovf <= ~ef_d[EXP_W+1] & ef_d[EXP_W];
                  exp_unf <= ef_d[EXP_W+1];
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fpx_addsub_checker.sv
`timescale 1ns/1ps
module fpx_addsub_checker #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [EXP_W-1:0] r_exp,
   input logic [MAN_W-1:0] r_man,
   input logic             exp_ovf,
   input logic             exp_unf
);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R12

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy) else $error("idle start not taken"); // R12

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))) else $error("done outside busy tail"); // R12

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({r_exp, r_man, exp_ovf, exp_unf})) else $error("result moved without done"); // R12

   AST_NORMALIZED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (r_man != '0)) |-> (r_man[MAN_W-1] != r_man[MAN_W-2])) else $error("result not normalized"); // R10

   AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (r_man == '0)) |-> ((r_exp == '0) && !exp_ovf && !exp_unf)) else $error("zero result not clean"); // R6

   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(exp_ovf && exp_unf)) else $error("both range flags set"); // R11

endmodule

bind fpx_addsub fpx_addsub_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .r_exp   (r_exp),
   .r_man   (r_man),
   .exp_ovf (exp_ovf),
   .exp_unf (exp_unf)
);

// File: tb/test_fpx_addsub.sv
`timescale 1ns/1ps
module test_fpx_addsub;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       sub = 1'b0;
   logic [1:0] rmode = 2'd0;
   logic [7:0] a_exp = '0, a_man = '0, b_exp = '0, b_man = '0;
   logic       busy, done, exp_ovf, exp_unf;
   logic [7:0] r_exp, r_man;

   always #5 clk = ~clk;

   fpx_addsub #(.EXP_W(8), .MAN_W(8)) i_fpx_addsub (
      .clk(clk), .rst_n(rst_n), .start(start), .sub(sub), .rmode(rmode),
      .a_exp(a_exp), .a_man(a_man), .b_exp(b_exp), .b_man(b_man),
      .busy(busy), .done(done), .r_exp(r_exp), .r_man(r_man),
      .exp_ovf(exp_ovf), .exp_unf(exp_unf)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    model_on = 0;
   string cur_tag = "R13";

   // model state: cnt 0 idle, 1..4 busy
   int m_cnt = 0, m_done = 0, m_e = 0, m_m = 0, m_o = 0, m_u = 0;
   int p_e = 0, p_m = 0, p_o = 0, p_u = 0;

   function automatic void chk(string tag, int act, int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endfunction

   // behavioural reference on plain integers
   task automatic ref_add(input int ea, input int ma, input int eb, input int mb,
                          input int sb, input int md,
                          output int re, output int rm, output int ro, output int ru);
      int sa, sbm, fa, fb, big, d, s, e, m, tail;
      bit lost;
      sa  = (ma >= 128) ? ma - 256 : ma;
      sbm = (mb >= 128) ? mb - 256 : mb;
      fa  = sa * 8;
      fb  = sbm * 8;
      big = (eb > ea) ? eb : ea;
      d   = (eb > ea) ? eb - ea : ea - eb;
      if (d > 20) d = 20;
      if (eb > ea) begin
         s = fa >>> d; lost = ((s <<< d) != fa); fa = s | int'(lost);
      end else begin
         s = fb >>> d; lost = ((s <<< d) != fb); fb = s | int'(lost);
      end
      s = (sb != 0) ? fa - fb : fa + fb;
      if (s == 0) begin
         re = 0; rm = 0; ro = 0; ru = 0;
         return;
      end
      e = big;
      if (s >= 1024 || s < -1024) begin
         s = (s >>> 1) | (s & 1);
         e = e + 1;
      end else begin
         while (!(s >= 512 || s < -512)) begin
            s = s * 2;
            e = e - 1;
         end
      end
      m    = s >>> 3;
      tail = s & 7;
      if (md == 1) m = m | 1;
      else if (md >= 2) begin
         if (tail > 4 || (tail == 4 && (m & 1) != 0)) m = m + 1;
      end
      if (m == 128) begin m = 64; e = e + 1; end
      else if (m == -64) begin m = -128; e = e - 1; end
      ro = (e > 255) ? 1 : 0;
      ru = (e < 0) ? 1 : 0;
      re = e & 255;
      rm = m & 255;
   endtask

   task automatic compare_all();
      if (!model_on) return;
      chk({cur_tag, " busy"}, int'(busy), (m_cnt != 0) ? 1 : 0);
      chk({cur_tag, " done"}, int'(done), m_done);
      chk({cur_tag, " r_exp"}, int'(r_exp), m_e);
      chk({cur_tag, " r_man"}, int'(r_man), m_m);
      chk({cur_tag, " exp_ovf"}, int'(exp_ovf), m_o);
      chk({cur_tag, " exp_unf"}, int'(exp_unf), m_u);
   endtask

   task automatic step(input bit st, input int ea, input int ma, input int eb,
                       input int mb, input bit sb, input int md);
      @(negedge clk);
      compare_all();
      start = st;
      a_exp = ea[7:0]; a_man = ma[7:0];
      b_exp = eb[7:0]; b_man = mb[7:0];
      sub   = sb;
      rmode = md[1:0];
      if (m_cnt == 4) begin
         m_e = p_e; m_m = p_m; m_o = p_o; m_u = p_u;
         m_cnt = 0; m_done = 1;
      end else begin
         m_done = 0;
         if (m_cnt > 0) m_cnt++;
         else if (st) begin
            ref_add(ea, ma, eb, mb, int'(sb), md, p_e, p_m, p_o, p_u);
            m_cnt = 1;
         end
      end
   endtask

   task automatic run_op(input int ea, input int ma, input int eb, input int mb,
                         input bit sb, input int md, input int xe, input int xm,
                         input int xo, input int xu, input string tag);
      cur_tag = tag;
      step(1'b1, ea, ma, eb, mb, sb, md);
      repeat (4) step(1'b0, ea, ma, eb, mb, sb, md);
      @(posedge clk);
      #1;
      chk({tag, " done pulse"}, int'(done), 1);
      chk({tag, " exp"}, int'(r_exp), xe);
      chk({tag, " man"}, int'(r_man), xm);
      chk({tag, " ovf"}, int'(exp_ovf), xo);
      chk({tag, " unf"}, int'(exp_unf), xu);
   endtask

   function automatic int rand_man();
      int r = int'($urandom);
      return ((r & 64) != 0) ? (8'h80 | (r & 8'h3F)) : (8'h40 | (r & 8'h3F));
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R12 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13: reset values
      chk("R13 busy", int'(busy), 0);
      chk("R13 done", int'(done), 0);
      chk("R13 r_exp", int'(r_exp), 0);
      chk("R13 r_man", int'(r_man), 0);
      chk("R13 flags", int'({exp_ovf, exp_unf}), 0);
      rst_n = 1'b1;
      model_on = 1;

      // R1: aligned add example
      run_op(8'h84, 8'h44, 8'h83, 8'h70, 1'b0, 0, 8'h84, 8'h7C, 0, 0, "R1");
      // R2: subtraction with alignment
      run_op(8'h80, 8'h60, 8'h7F, 8'h40, 1'b1, 0, 8'h80, 8'h40, 0, 0, "R2");
      // R3: whole operand lands in sticky, then truncation sees it
      run_op(8'h80, 8'h40, 8'h70, 8'h7F, 1'b1, 0, 8'h7F, 8'h7F, 0, 0, "R3");
      // R4: carry out, right shift
      run_op(8'h80, 8'h7F, 8'h80, 8'h7F, 1'b0, 0, 8'h81, 8'h7F, 0, 0, "R4");
      // R5: cancellation, seven left shifts
      run_op(8'h85, 8'h40, 8'h85, 8'h41, 1'b1, 0, 8'h7E, 8'h80, 0, 0, "R5");
      // R6: exact zero
      run_op(8'h90, 8'h55, 8'h90, 8'h55, 1'b1, 2, 8'h00, 8'h00, 0, 0, "R6");
      // R7: truncate, tail 100
      run_op(8'h83, 8'h40, 8'h80, 8'h4C, 1'b0, 0, 8'h83, 8'h49, 0, 0, "R7");
      // R8: jam LSB
      run_op(8'h83, 8'h40, 8'h80, 8'h44, 1'b0, 1, 8'h83, 8'h49, 0, 0, "R8");
      // R9: nearest, tie with odd LSB, tie with even LSB, tail above half, code 3
      run_op(8'h83, 8'h40, 8'h80, 8'h4C, 1'b0, 2, 8'h83, 8'h4A, 0, 0, "R9");
      run_op(8'h83, 8'h40, 8'h80, 8'h44, 1'b0, 2, 8'h83, 8'h48, 0, 0, "R9");
      run_op(8'h83, 8'h40, 8'h80, 8'h45, 1'b0, 2, 8'h83, 8'h49, 0, 0, "R9");
      run_op(8'h83, 8'h40, 8'h80, 8'h4C, 1'b0, 3, 8'h83, 8'h4A, 0, 0, "R9");
      // R10: rounding overflow positive, and negative collapse
      run_op(8'h87, 8'h7F, 8'h80, 8'h50, 1'b0, 2, 8'h88, 8'h40, 0, 0, "R10");
      run_op(8'h87, 8'h7F, 8'h80, 8'h50, 1'b0, 0, 8'h87, 8'h7F, 0, 0, "R10");
      run_op(8'h80, 8'hBF, 8'h79, 8'h50, 1'b0, 2, 8'h7F, 8'h80, 0, 0, "R10");
      // R11: exponent overflow and underflow
      run_op(8'hFF, 8'h7F, 8'hFF, 8'h7F, 1'b0, 0, 8'h00, 8'h7F, 1, 0, "R11");
      run_op(8'h02, 8'h40, 8'h02, 8'h41, 1'b1, 0, 8'hFB, 8'h80, 0, 1, "R11");

      // R12: starts while busy are ignored
      cur_tag = "R12";
      step(1'b1, 8'h84, 8'h44, 8'h83, 8'h70, 1'b0, 0);
      step(1'b1, 8'h10, 8'hA0, 8'h20, 8'h60, 1'b1, 2);
      step(1'b1, 8'h30, 8'h50, 8'h31, 8'h90, 1'b0, 1);
      step(1'b1, 8'hF0, 8'h7F, 8'h01, 8'h40, 1'b1, 3);
      step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 0);
      @(posedge clk);
      #1;
      chk("R12 ignored start exp", int'(r_exp), 8'h84);
      chk("R12 ignored start man", int'(r_man), 8'h7C);

      // R2: random traffic, overlapping starts, all modes
      cur_tag = "R2 random";
      for (int n = 0; n < 3000; n++) begin
         int ea, eb, ma, mb;
         ea = int'($urandom_range(0, 255));
         eb = ea + int'($urandom_range(0, 20)) - 10;
         if (eb < 0) eb = 0;
         if (eb > 255) eb = 255;
         ma = rand_man();
         mb = (($urandom & 7) == 0) ? ma : rand_man();
         step(($urandom % 3) == 0, ea, ma, eb, mb, $urandom_range(0, 1) != 0,
              int'($urandom_range(0, 3)));
      end
      repeat (6) step(1'b0, 0, 0, 0, 0, 1'b0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule